// File: doc/BRIEF.md
# Flash Page Write-Once Tracker

This block keeps the programming rules of a small flash array built from blocks of pages. It stores each page's data and a per-page state, and serves three single-page or single-block requests: read a page, program a page and erase a block. A page can be programmed only while it is erased. After that it stays written until its whole block is erased. When a program replaces data held elsewhere, the requester can name the older page, and the tracker marks that page stale.

A block that still holds live data cannot be erased directly. A fourth request, relocate, does this job. It walks the pages of a victim block in ascending order and copies each valid page into the next free page of an erased target block. It then erases the victim. During this sequence a busy flag is raised, and any request presented while busy is high is dropped. Every accepted request gives a one-cycle response that carries an error flag and, for reads, the page data and state.

Top module: `flash_page_tracker`

## Requirements
- R1: After reset every page is in state erased (encoding 2'b00), reads back data of all ones, and busy_o is low.
- R2: A read (op 2'b00) produces rsp_valid_o with rsp_err_o low one cycle after acceptance, carrying the page data and its state (erased 2'b00, valid 2'b01, stale 2'b10).
- R3: A program (op 2'b01) to an erased page succeeds without error, stores the data and moves the page to valid.
- R4: A program to a page that is valid or stale is refused with rsp_err_o high, and the page data and state are left unchanged.
- R5: A successful program with sup_en_i high moves the page named by sup_blk_i/sup_page_i from valid to stale, and its data is kept.
- R6: An erase (op 2'b10) of a block with no valid page succeeds and returns each of its pages to erased with all-ones data, so that each page can be programmed again.
- R7: An erase of a block that holds any valid page is refused with an error, and the block is unchanged.
- R8: A relocate (op 2'b11) copies the victim's valid pages, in ascending page order, into target pages 0, 1, 2 and onward as valid pages. It skips stale and erased pages and then erases the victim. The response carries no error.
- R9: A relocate whose target block is not fully erased, or is the victim itself, is refused with an error, no sequence starts and busy_o stays low.
- R10: After a relocate is accepted, busy_o is high for exactly PAGES_PER_BLOCK+1 cycles. Its response arrives in the cycle busy_o falls, and requests presented while busy_o is high get no response and have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| req_valid_i | input | 1 | Request present |
| req_op_i | input | 2 | 00 read, 01 program, 10 erase, 11 relocate |
| req_blk_i | input | $clog2(NUM_BLOCKS) | Block addressed (victim for relocate) |
| req_page_i | input | $clog2(PAGES_PER_BLOCK) | Page within block |
| req_data_i | input | DATA_W | Program data |
| sup_en_i | input | 1 | Program supersedes an older page |
| sup_blk_i | input | $clog2(NUM_BLOCKS) | Block of superseded page |
| sup_page_i | input | $clog2(PAGES_PER_BLOCK) | Page of superseded page |
| tgt_blk_i | input | $clog2(NUM_BLOCKS) | Relocation target block |
| busy_o | output | 1 | Relocation sequence in progress |
| rsp_valid_o | output | 1 | Response strobe |
| rsp_err_o | output | 1 | Request refused |
| rsp_state_o | output | 2 | Page state seen at read |
| rsp_data_o | output | DATA_W | Page data for read |

## Verification
Programs are aimed at erased, valid and stale pages. This separates the one legal transition from the two refused ones, and a readback after each refusal confirms that nothing changed. Erases are tried on a block with only stale pages and on a block with a live page, which tells whether the refusal looks at liveness rather than at any written content. Relocation runs on a victim that mixes stale, valid and erased pages, so a copy that ignores state or order would put the wrong data in target pages 0 and 1. Target checks use a non-empty block and the victim itself. A program presented during the busy window must leave no trace.

// File: rtl/fpt_pkg.sv
package fpt_pkg;
  typedef enum logic [1:0] {
    PG_ERASED = 2'b00,
    PG_VALID  = 2'b01,
    PG_STALE  = 2'b10
  } pg_state_e;

  typedef enum logic [1:0] {
    OP_READ  = 2'b00,
    OP_PROG  = 2'b01,
    OP_ERASE = 2'b10,
    OP_RELOC = 2'b11
  } op_e;
endpackage

// File: rtl/fpt_page_store.sv
module fpt_page_store
  import fpt_pkg::*;
#(
  parameter int NUM_BLOCKS      = 4,
  parameter int PAGES_PER_BLOCK = 4,
  parameter int DATA_W          = 8,
  localparam int BW = $clog2(NUM_BLOCKS),
  localparam int PW = $clog2(PAGES_PER_BLOCK),
  localparam int NP = NUM_BLOCKS * PAGES_PER_BLOCK
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_en_i,
  input  logic [BW+PW-1:0]  wr_idx_i,
  input  logic [DATA_W-1:0] wr_data_i,
  input  logic              mk_en_i,
  input  logic [BW+PW-1:0]  mk_idx_i,
  input  logic              er_en_i,
  input  logic [BW-1:0]     er_blk_i,
  input  logic [BW+PW-1:0]  rd_idx_i,
  output pg_state_e         rd_state_o,
  output logic [DATA_W-1:0] rd_data_o,
  input  logic [BW+PW-1:0]  rd2_idx_i,
  output pg_state_e         rd2_state_o,
  output logic [DATA_W-1:0] rd2_data_o,
  output logic [NUM_BLOCKS-1:0] blk_erased_o,
  output logic [NUM_BLOCKS-1:0] blk_live_o
);
  pg_state_e         st_q  [NP];
  logic [DATA_W-1:0] dat_q [NP];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 0; i < NP; i++) begin
        st_q[i]  <= PG_ERASED;
        dat_q[i] <= '1;
      end
    end else begin
      if (mk_en_i && st_q[mk_idx_i] == PG_VALID) st_q[mk_idx_i] <= PG_STALE;
      if (wr_en_i) begin
        st_q[wr_idx_i]  <= PG_VALID;
        dat_q[wr_idx_i] <= wr_data_i;
      end
      if (er_en_i) begin
        for (int p = 0; p < PAGES_PER_BLOCK; p++) begin
          st_q[{er_blk_i, PW'(p)}]  <= PG_ERASED;
          dat_q[{er_blk_i, PW'(p)}] <= '1;
        end
      end
    end
  end

  assign rd_state_o  = st_q[rd_idx_i];
  assign rd_data_o   = dat_q[rd_idx_i];
  assign rd2_state_o = st_q[rd2_idx_i];
  assign rd2_data_o  = dat_q[rd2_idx_i];

  for (genvar b = 0; b < NUM_BLOCKS; b++) begin : g_blk
    logic [PAGES_PER_BLOCK-1:0] pg_er, pg_live;
    for (genvar p = 0; p < PAGES_PER_BLOCK; p++) begin : g_pg
      assign pg_er[p]   = st_q[b*PAGES_PER_BLOCK+p] == PG_ERASED;
      assign pg_live[p] = st_q[b*PAGES_PER_BLOCK+p] == PG_VALID;
    end
    assign blk_erased_o[b] = &pg_er;
    assign blk_live_o[b]   = |pg_live;
  end

  p_no_rewrite_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_en_i |-> st_q[wr_idx_i] == PG_ERASED);

  p_no_live_erase_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    er_en_i |-> !blk_live_o[er_blk_i]);

  p_erase_clears_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    er_en_i |=> blk_erased_o[$past(er_blk_i)]);
endmodule

// File: rtl/fpt_reloc_seq.sv
module fpt_reloc_seq
  import fpt_pkg::*;
#(
  parameter int NUM_BLOCKS      = 4,
  parameter int PAGES_PER_BLOCK = 4,
  localparam int BW = $clog2(NUM_BLOCKS),
  localparam int PW = $clog2(PAGES_PER_BLOCK)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             start_i,
  input  logic [BW-1:0]    vic_blk_i,
  input  logic [BW-1:0]    tgt_blk_i,
  input  pg_state_e        src_state_i,
  output logic             busy_o,
  output logic [BW+PW-1:0] src_idx_o,
  output logic             copy_en_o,
  output logic [BW+PW-1:0] dst_idx_o,
  output logic             erase_en_o,
  output logic [BW-1:0]    erase_blk_o
);
  typedef enum logic [1:0] {S_IDLE, S_COPY, S_ERASE} seq_e;
  seq_e          st_q;
  logic [BW-1:0] vic_q, tgt_q;
  logic [PW-1:0] pg_q, dst_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q  <= S_IDLE;
      vic_q <= '0;
      tgt_q <= '0;
      pg_q  <= '0;
      dst_q <= '0;
    end else begin
      unique case (st_q)
        S_IDLE: if (start_i) begin
          st_q  <= S_COPY;
          vic_q <= vic_blk_i;
          tgt_q <= tgt_blk_i;
          pg_q  <= '0;
          dst_q <= '0;
        end
        S_COPY: begin
          if (copy_en_o) dst_q <= dst_q + 1'b1;
          pg_q <= pg_q + 1'b1;
          if (pg_q == PW'(PAGES_PER_BLOCK-1)) st_q <= S_ERASE;
        end
        S_ERASE: st_q <= S_IDLE;
        default: st_q <= S_IDLE;
      endcase
    end
  end

  assign busy_o      = st_q != S_IDLE;
  assign src_idx_o   = {vic_q, pg_q};
  assign dst_idx_o   = {tgt_q, dst_q};
  assign copy_en_o   = st_q == S_COPY && src_state_i == PG_VALID;
  assign erase_en_o  = st_q == S_ERASE;
  assign erase_blk_o = vic_q;

  p_busy_holds_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_o && !erase_en_o) |=> busy_o);

  p_start_busy_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (start_i && !busy_o) |=> busy_o);
endmodule

// File: rtl/flash_page_tracker.sv
module flash_page_tracker
  import fpt_pkg::*;
#(
  parameter int NUM_BLOCKS      = 4,
  parameter int PAGES_PER_BLOCK = 4,
  parameter int DATA_W          = 8,
  localparam int BW = $clog2(NUM_BLOCKS),
  localparam int PW = $clog2(PAGES_PER_BLOCK)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              req_valid_i,
  input  logic [1:0]        req_op_i,
  input  logic [BW-1:0]     req_blk_i,
  input  logic [PW-1:0]     req_page_i,
  input  logic [DATA_W-1:0] req_data_i,
  input  logic              sup_en_i,
  input  logic [BW-1:0]     sup_blk_i,
  input  logic [PW-1:0]     sup_page_i,
  input  logic [BW-1:0]     tgt_blk_i,
  output logic              busy_o,
  output logic              rsp_valid_o,
  output logic              rsp_err_o,
  output logic [1:0]        rsp_state_o,
  output logic [DATA_W-1:0] rsp_data_o
);
  logic              accept, busy;
  op_e               op;
  pg_state_e         rd_state, src_state;
  logic [DATA_W-1:0] rd_data, src_data;
  logic [NUM_BLOCKS-1:0] blk_erased, blk_live;
  logic              prog_ok, erase_ok, reloc_ok;
  logic              seq_copy, seq_erase;
  logic [BW+PW-1:0]  src_idx, dst_idx;
  logic [BW-1:0]     seq_erase_blk;

  logic              wr_en, mk_en, er_en;
  logic [BW+PW-1:0]  wr_idx, mk_idx;
  logic [DATA_W-1:0] wr_data;
  logic [BW-1:0]     er_blk;

  assign op       = op_e'(req_op_i);
  assign accept   = req_valid_i && !busy;
  assign prog_ok  = rd_state == PG_ERASED;
  assign erase_ok = !blk_live[req_blk_i];
  assign reloc_ok = blk_erased[tgt_blk_i] && tgt_blk_i != req_blk_i;

  always_comb begin
    wr_en   = 1'b0;
    wr_idx  = {req_blk_i, req_page_i};
    wr_data = req_data_i;
    mk_en   = 1'b0;
    mk_idx  = {sup_blk_i, sup_page_i};
    er_en   = 1'b0;
    er_blk  = req_blk_i;
    if (busy) begin
      wr_en   = seq_copy;
      wr_idx  = dst_idx;
      wr_data = src_data;
      mk_en   = seq_copy;
      mk_idx  = src_idx;
      er_en   = seq_erase;
      er_blk  = seq_erase_blk;
    end else if (accept) begin
      wr_en = op == OP_PROG && prog_ok;
      mk_en = op == OP_PROG && prog_ok && sup_en_i;
      er_en = op == OP_ERASE && erase_ok;
    end
  end

  fpt_page_store #(
    .NUM_BLOCKS(NUM_BLOCKS), .PAGES_PER_BLOCK(PAGES_PER_BLOCK), .DATA_W(DATA_W)
  ) u_store (
    .clk_i, .rst_ni,
    .wr_en_i(wr_en), .wr_idx_i(wr_idx), .wr_data_i(wr_data),
    .mk_en_i(mk_en), .mk_idx_i(mk_idx),
    .er_en_i(er_en), .er_blk_i(er_blk),
    .rd_idx_i({req_blk_i, req_page_i}), .rd_state_o(rd_state), .rd_data_o(rd_data),
    .rd2_idx_i(src_idx), .rd2_state_o(src_state), .rd2_data_o(src_data),
    .blk_erased_o(blk_erased), .blk_live_o(blk_live)
  );

  fpt_reloc_seq #(
    .NUM_BLOCKS(NUM_BLOCKS), .PAGES_PER_BLOCK(PAGES_PER_BLOCK)
  ) u_seq (
    .clk_i, .rst_ni,
    .start_i(accept && op == OP_RELOC && reloc_ok),
    .vic_blk_i(req_blk_i), .tgt_blk_i(tgt_blk_i),
    .src_state_i(src_state),
    .busy_o(busy), .src_idx_o(src_idx),
    .copy_en_o(seq_copy), .dst_idx_o(dst_idx),
    .erase_en_o(seq_erase), .erase_blk_o(seq_erase_blk)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rsp_valid_o <= 1'b0;
      rsp_err_o   <= 1'b0;
      rsp_state_o <= PG_ERASED;
      rsp_data_o  <= '0;
    end else begin
      rsp_valid_o <= 1'b0;
      rsp_err_o   <= 1'b0;
      if (busy) begin
        if (seq_erase) rsp_valid_o <= 1'b1;
      end else if (accept) begin
        rsp_state_o <= rd_state;
        rsp_data_o  <= op == OP_READ ? rd_data : '0;
        unique case (op)
          OP_READ: begin
            rsp_valid_o <= 1'b1;
          end
          OP_PROG: begin
            rsp_valid_o <= 1'b1;
            rsp_err_o   <= !prog_ok;
          end
          OP_ERASE: begin
            rsp_valid_o <= 1'b1;
            rsp_err_o   <= !erase_ok;
          end
          OP_RELOC: begin
            rsp_valid_o <= !reloc_ok;
            rsp_err_o   <= !reloc_ok;
          end
          default: ;
        endcase
      end
    end
  end

  assign busy_o = busy;

  p_prog_err_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (accept && op == OP_PROG && rd_state != PG_ERASED) |=> (rsp_valid_o && rsp_err_o));

  p_busy_silent_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy && !seq_erase) |=> !rsp_valid_o);
endmodule

// File: tb/tb_flash_page_tracker.sv
module tb_flash_page_tracker;
  localparam int NB = 4, PP = 4, DW = 8;

  logic clk = 1'b0, rst_n = 1'b0;
  logic req_valid = 1'b0, sup_en = 1'b0;
  logic [1:0] req_op = '0;
  logic [1:0] req_blk = '0, sup_blk = '0, tgt_blk = '0;
  logic [1:0] req_page = '0, sup_page = '0;
  logic [DW-1:0] req_data = '0;
  logic busy, rsp_valid, rsp_err;
  logic [1:0] rsp_state;
  logic [DW-1:0] rsp_data;
  int n_chk = 0, n_fail = 0;

  always #2 clk = ~clk;

  flash_page_tracker #(.NUM_BLOCKS(NB), .PAGES_PER_BLOCK(PP), .DATA_W(DW)) dut (
    .clk_i(clk), .rst_ni(rst_n), .req_valid_i(req_valid), .req_op_i(req_op),
    .req_blk_i(req_blk), .req_page_i(req_page), .req_data_i(req_data),
    .sup_en_i(sup_en), .sup_blk_i(sup_blk), .sup_page_i(sup_page),
    .tgt_blk_i(tgt_blk), .busy_o(busy), .rsp_valid_o(rsp_valid),
    .rsp_err_o(rsp_err), .rsp_state_o(rsp_state), .rsp_data_o(rsp_data)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  // one accepted request; response sampled at the following falling edge
  task automatic issue(input logic [1:0] op, input int b, input int p, input int d,
                       input logic sup, input int sb, input int sp, input int tb);
    @(negedge clk);
    req_valid = 1'b1; req_op = op; req_blk = 2'(b); req_page = 2'(p);
    req_data = 8'(d); sup_en = sup; sup_blk = 2'(sb); sup_page = 2'(sp); tgt_blk = 2'(tb);
    @(negedge clk);
    req_valid = 1'b0; sup_en = 1'b0;
  endtask

  task automatic rd_chk(input string req, input int b, input int p, input int st, input int d);
    issue(2'b00, b, p, 0, 1'b0, 0, 0, 0);
    chk({req, " rsp"}, {rsp_valid, rsp_err}, 2'b10);
    chk({req, " state"}, rsp_state, st);
    chk({req, " data"}, rsp_data, d);
  endtask

  task automatic prog(input string req, input int b, input int p, input int d,
                      input logic sup, input int sb, input int sp, input logic exp_err);
    issue(2'b01, b, p, d, sup, sb, sp, 0);
    chk({req, " program rsp"}, {rsp_valid, rsp_err}, {1'b1, exp_err});
  endtask

  task automatic t_reset;
    chk("R1 busy", busy, 0);
    rd_chk("R1", 0, 0, 0, 8'hFF);
    rd_chk("R1", 3, 3, 0, 8'hFF);
  endtask

  task automatic t_program;
    prog("R3", 1, 0, 8'hA5, 1'b0, 0, 0, 1'b0);
    rd_chk("R2 R3", 1, 0, 1, 8'hA5);
  endtask

  task automatic t_reprogram;
    prog("R4 valid", 1, 0, 8'h3C, 1'b0, 0, 0, 1'b1);
    rd_chk("R4 valid unchanged", 1, 0, 1, 8'hA5);
  endtask

  task automatic t_supersede;
    prog("R5", 1, 1, 8'h77, 1'b1, 1, 0, 1'b0);
    rd_chk("R5 old stale", 1, 0, 2, 8'hA5);
    rd_chk("R5 new valid", 1, 1, 1, 8'h77);
    prog("R4 stale", 1, 0, 8'h11, 1'b0, 0, 0, 1'b1);
    rd_chk("R4 stale unchanged", 1, 0, 2, 8'hA5);
  endtask

  task automatic t_erase_refused;
    issue(2'b10, 1, 0, 0, 1'b0, 0, 0, 0);
    chk("R7 erase rsp", {rsp_valid, rsp_err}, 2'b11);
    rd_chk("R7 block kept", 1, 1, 1, 8'h77);
  endtask

  task automatic t_erase_ok;
    prog("R6 setup", 2, 0, 8'h22, 1'b0, 0, 0, 1'b0);
    prog("R6 setup", 1, 2, 8'h33, 1'b1, 2, 0, 1'b0);
    issue(2'b10, 2, 0, 0, 1'b0, 0, 0, 0);
    chk("R6 erase rsp", {rsp_valid, rsp_err}, 2'b10);
    rd_chk("R6 erased", 2, 0, 0, 8'hFF);
    prog("R6 reprogram", 2, 0, 8'h44, 1'b0, 0, 0, 1'b0);
    rd_chk("R6 reprogram", 2, 0, 1, 8'h44);
  endtask

  task automatic t_reloc_bad;
    issue(2'b11, 1, 0, 0, 1'b0, 0, 0, 2);
    chk("R9 busy target", {rsp_valid, rsp_err, busy}, 3'b110);
    issue(2'b11, 3, 0, 0, 1'b0, 0, 0, 3);
    chk("R9 self target", {rsp_valid, rsp_err, busy}, 3'b110);
    rd_chk("R9 victim kept", 1, 1, 1, 8'h77);
  endtask

  // relocate; optionally present a program while busy
  task automatic reloc(input string req, input int v, input int t, input logic poke);
    int cyc = 0;
    int extra = 0;
    issue(2'b11, v, 0, 0, 1'b0, 0, 0, t);
    while (!rsp_valid && cyc < 20) begin
      chk({req, " R10 busy"}, busy, 1);
      if (poke && cyc == 1) begin
        req_valid = 1'b1; req_op = 2'b01; req_blk = 2'd0; req_page = 2'd3; req_data = 8'h99;
      end else req_valid = 1'b0;
      cyc++;
      @(negedge clk);
      if (rsp_valid && cyc < PP) extra++;
    end
    req_valid = 1'b0;
    chk({req, " R10 busy cycles"}, cyc, PP + 1);
    chk({req, " R10 no early rsp"}, extra, 0);
    chk({req, " R8 rsp"}, {rsp_valid, rsp_err, busy}, 3'b100);
  endtask

  task automatic t_reloc;
    reloc("R8", 1, 3, 1'b0);
    rd_chk("R8 first copy", 3, 0, 1, 8'h77);
    rd_chk("R8 second copy", 3, 1, 1, 8'h33);
    rd_chk("R8 tail free", 3, 2, 0, 8'hFF);
    rd_chk("R8 victim erased", 1, 0, 0, 8'hFF);
    rd_chk("R8 victim erased", 1, 2, 0, 8'hFF);
  endtask

  task automatic t_busy_ignore;
    reloc("R10 poke", 2, 1, 1'b1);
    rd_chk("R10 ignored program", 0, 3, 0, 8'hFF);
    rd_chk("R10 moved page", 1, 0, 1, 8'h44);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    t_program();
    t_reprogram();
    t_supersede();
    t_erase_refused();
    t_erase_ok();
    t_reloc_bad();
    t_reloc();
    t_busy_ignore();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    #40000;
    n_chk++;
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule